// File: doc/BRIEF.md
# I2C Master Bit-Level Sequencer

This block is the single master on an open-drain I2C bus. It turns byte-level commands into timed wire events on SCL and SDA. A controller issues one of four commands over a valid/ready port: START, STOP, WRITE (shift a byte out, then capture the target's acknowledge) or READ (shift a byte in, then answer it). Each phase of the bus waveform lasts a fixed number of system-clock cycles. That count comes from a fast-mode minimum duration in nanoseconds and the clock frequency in kHz, and every phase lasts at least one cycle.

SDA is modelled as an output enable plus a data value. The bus high level always comes from the pull-up, never from this block: SDA is released whenever SCL goes low during a bit, and STOP finishes by releasing SDA rather than driving it high. The SDA input passes through a two-flop synchronizer before the bit is captured. Only one command is in flight at a time. An address phase is an ordinary WRITE whose byte is the 7-bit target address shifted up by one, with the read/write flag in bit 0 (1 = read).

Top module: `i2c_bit_seq`

## Requirements
- R1: After synchronous active-high reset the block is idle: `scl_o`=1, `sda_oe`=0, `sda_o`=0, `cmd_ready`=1, `rsp_done`=0.
- R2: START (`cmd_op`=0) drives SCL high with SDA driven high for the start-setup count (7 cycles at defaults). It then drives SDA low for the start-hold count (7). It then pulls SCL low with SDA still driven low for the SCL-low count (16).
- R3: STOP (`cmd_op`=1) drives SDA low with SCL unchanged for the clock-to-data count (11). It then raises SCL for the stop-setup count (7). It then releases SDA for the bus-free count (16), leaving SCL high and SDA released.
- R4: WRITE (`cmd_op`=2) sends `cmd_wdata` MSB first. Each bit releases SDA for clock-to-data minus data-setup cycles (10), drives the bit for the data-setup count (1), holds SCL high with the bit driven for the SCL-high count (7), then holds SCL low with SDA released for SCL-low minus clock-to-data cycles (5).
- R5: After the eighth written bit a receive slot follows: SDA released for 11 cycles, SCL high for 7, SCL low for 5. The level captured there is reported on `rsp_nack` (0 = acknowledged, 1 = error).
- R6: READ (`cmd_op`=3) performs eight receive slots, MSB first, and returns the byte on `rsp_rdata`. It then sends one bit with the R4 timing: 0 when `cmd_last`=0, 1 when `cmd_last`=1.
- R7: Whenever SCL falls during a bit, SDA is released in the same cycle. At no SCL fall is SDA driven high.
- R8: `cmd_ready` falls the cycle after acceptance and stays low until `rsp_done`. `rsp_done` is a one-cycle pulse coinciding with `cmd_ready` returning high. `cmd_valid` while busy is ignored.
- R9: `rsp_rdata` changes only at the done of a READ, and `rsp_nack` only at the done of a WRITE. Both hold their values across all other commands.
- R10: A received bit is the SDA level seen three cycles before the end of the SCL-high phase. A change of SDA in the last two SCL-high cycles does not alter the captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System/timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and able to accept |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_wdata | input | 8 | Byte to send on WRITE |
| cmd_last | input | 1 | READ: answer with NACK instead of ACK |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last READ |
| rsp_nack | output | 1 | Acknowledge level captured by the last WRITE |
| scl_o | output | 1 | SCL level driven onto the bus |
| sda_oe | output | 1 | SDA driver enable (0 = released to pull-up) |
| sda_o | output | 1 | SDA value when enabled |
| sda_in | input | 1 | SDA bus level |

## Verification
The hardest case to reach from the ports is a target that changes SDA inside the last two SCL-high cycles of a receive slot. Only the synchronizer's latency keeps that change out of the captured bit. The bench's target model flips its SDA level exactly in that window on every bit of one READ, and checks that the returned byte matches the level held before the flip. A second corner is a command presented while busy: the bench holds `cmd_valid` high with a different opcode through the start of a WRITE, and compares the waveform cycle by cycle to show that the request was ignored.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } i2cseq_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_STA_SU,
    S_STA_HD,
    S_STA_LO,
    S_STO_LO,
    S_STO_SU,
    S_STO_BUF,
    S_BIT_REL,
    S_BIT_DRV,
    S_BIT_HI,
    S_BIT_LO
  } i2cseq_state_e;

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // nanoseconds to whole clock cycles, truncating, never below one
  function automatic int ns2cyc(input int ns, input int clk_khz);
    longint prod;
    prod = longint'(ns) * longint'(clk_khz);
    return at_least_one(int'(prod / 64'sd1000000));
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/i2cseq_sync.sv
module i2cseq_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import i2cseq_pkg::*;
#(
  parameter int CLK_KHZ     = 12500,
  parameter int T_LOW_NS    = 1300,
  parameter int T_HIGH_NS   = 600,
  parameter int T_SUDAT_NS  = 100,
  parameter int T_HDSTA_NS  = 600,
  parameter int T_SUSTA_NS  = 600,
  parameter int T_SUSTO_NS  = 600,
  parameter int T_BUF_NS    = 1300,
  parameter int T_C2D_NS    = 900,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       cmd_last,
  output logic       rsp_done,
  output logic [7:0] rsp_rdata,
  output logic       rsp_nack,
  output logic       scl_o,
  output logic       sda_oe,
  output logic       sda_o,
  input  logic       sda_in
);

  // phase lengths in cycles
  localparam int C_LOW   = ns2cyc(T_LOW_NS,   CLK_KHZ);
  localparam int C_HIGH  = ns2cyc(T_HIGH_NS,  CLK_KHZ);
  localparam int C_SUDAT = ns2cyc(T_SUDAT_NS, CLK_KHZ);
  localparam int C_HDSTA = ns2cyc(T_HDSTA_NS, CLK_KHZ);
  localparam int C_SUSTA = ns2cyc(T_SUSTA_NS, CLK_KHZ);
  localparam int C_SUSTO = ns2cyc(T_SUSTO_NS, CLK_KHZ);
  localparam int C_BUF   = ns2cyc(T_BUF_NS,   CLK_KHZ);
  localparam int C_C2D   = ns2cyc(T_C2D_NS,   CLK_KHZ);
  // released gap before a driven bit, and the low tail after every bit
  localparam int C_TXREL = at_least_one(C_C2D - C_SUDAT);
  localparam int C_TAIL  = at_least_one(C_LOW - C_C2D);

  localparam int C_MAX = max2(max2(max2(C_LOW, C_HIGH), max2(C_SUDAT, C_HDSTA)),
                              max2(max2(C_SUSTA, C_SUSTO), max2(C_BUF, C_C2D)));
  localparam int CW    = $clog2(C_MAX + 1);
  localparam int IDX_W = $clog2(BYTE_W + 1);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(BYTE_W);

  i2cseq_state_e     st, st_n;
  i2cseq_op_e        op_q, op_n;
  logic              last_q, last_n;
  logic [IDX_W-1:0]  idx, idx_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              ack_q, ack_n;
  logic              scl_n, oe_n, dout_n;
  logic              ld;
  logic [CW-1:0]     ldv;
  logic              fin;
  logic              tmr_zero;
  logic              sda_s;
  logic              cur_tx;
  logic              tx_val;

  i2cseq_timer #(
    .W(CW)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ldv),
    .zero     (tmr_zero)
  );

  i2cseq_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sda_in),
    .q   (sda_s)
  );

  // which of the nine slots the master drives
  function automatic logic slot_is_tx(input i2cseq_op_e op, input logic [IDX_W-1:0] i);
    if (op == OP_WRITE) begin
      return (i != LAST_SLOT);
    end
    return (i == LAST_SLOT);
  endfunction

  assign cur_tx = slot_is_tx(op_q, idx);
  assign tx_val = (op_q == OP_WRITE) ? sh[BYTE_W-1] : last_q;

  always_comb begin
    st_n   = st;
    op_n   = op_q;
    last_n = last_q;
    idx_n  = idx;
    sh_n   = sh;
    ack_n  = ack_q;
    scl_n  = scl_o;
    oe_n   = sda_oe;
    dout_n = sda_o;
    ld     = 1'b0;
    ldv    = '0;
    fin    = 1'b0;

    unique case (st)
      S_IDLE: begin
        if (cmd_valid) begin
          op_n   = i2cseq_op_e'(cmd_op);
          last_n = cmd_last;
          ld     = 1'b1;
          unique case (i2cseq_op_e'(cmd_op))
            OP_START: begin
              st_n   = S_STA_SU;
              scl_n  = 1'b1;
              oe_n   = 1'b1;
              dout_n = 1'b1;
              ldv    = CW'(C_SUSTA - 1);
            end
            OP_STOP: begin
              st_n   = S_STO_LO;
              oe_n   = 1'b1;
              dout_n = 1'b0;
              ldv    = CW'(C_C2D - 1);
            end
            OP_WRITE: begin
              st_n   = S_BIT_REL;
              sh_n   = cmd_wdata;
              idx_n  = '0;
              oe_n   = 1'b0;
              dout_n = 1'b0;
              ldv    = CW'(C_TXREL - 1);
            end
            OP_READ: begin
              st_n   = S_BIT_REL;
              sh_n   = '0;
              idx_n  = '0;
              oe_n   = 1'b0;
              dout_n = 1'b0;
              ldv    = CW'(C_C2D - 1);
            end
          endcase
        end
      end

      S_STA_SU: begin
        if (tmr_zero) begin
          st_n   = S_STA_HD;
          dout_n = 1'b0;
          ld     = 1'b1;
          ldv    = CW'(C_HDSTA - 1);
        end
      end

      S_STA_HD: begin
        if (tmr_zero) begin
          // SDA stays driven low through this clock fall
          st_n  = S_STA_LO;
          scl_n = 1'b0;
          ld    = 1'b1;
          ldv   = CW'(C_LOW - 1);
        end
      end

      S_STA_LO: begin
        if (tmr_zero) begin
          st_n = S_IDLE;
          fin  = 1'b1;
        end
      end

      S_STO_LO: begin
        if (tmr_zero) begin
          st_n  = S_STO_SU;
          scl_n = 1'b1;
          ld    = 1'b1;
          ldv   = CW'(C_SUSTO - 1);
        end
      end

      S_STO_SU: begin
        if (tmr_zero) begin
          // pull-up finishes the STOP
          st_n   = S_STO_BUF;
          oe_n   = 1'b0;
          dout_n = 1'b0;
          ld     = 1'b1;
          ldv    = CW'(C_BUF - 1);
        end
      end

      S_STO_BUF: begin
        if (tmr_zero) begin
          st_n = S_IDLE;
          fin  = 1'b1;
        end
      end

      S_BIT_REL: begin
        if (tmr_zero) begin
          ld = 1'b1;
          if (cur_tx) begin
            st_n   = S_BIT_DRV;
            oe_n   = 1'b1;
            dout_n = tx_val;
            ldv    = CW'(C_SUDAT - 1);
          end else begin
            st_n  = S_BIT_HI;
            scl_n = 1'b1;
            ldv   = CW'(C_HIGH - 1);
          end
        end
      end

      S_BIT_DRV: begin
        if (tmr_zero) begin
          st_n  = S_BIT_HI;
          scl_n = 1'b1;
          ld    = 1'b1;
          ldv   = CW'(C_HIGH - 1);
        end
      end

      S_BIT_HI: begin
        if (tmr_zero) begin
          st_n   = S_BIT_LO;
          scl_n  = 1'b0;
          oe_n   = 1'b0;
          dout_n = 1'b0;
          ld     = 1'b1;
          ldv    = CW'(C_TAIL - 1);
          if (!cur_tx) begin
            if (idx == LAST_SLOT) begin
              ack_n = sda_s;
            end else begin
              sh_n = {sh[BYTE_W-2:0], sda_s};
            end
          end else if (op_q == OP_WRITE) begin
            sh_n = {sh[BYTE_W-2:0], 1'b0};
          end
        end
      end

      S_BIT_LO: begin
        if (tmr_zero) begin
          if (idx == LAST_SLOT) begin
            st_n = S_IDLE;
            fin  = 1'b1;
          end else begin
            idx_n  = idx + 1'b1;
            st_n   = S_BIT_REL;
            oe_n   = 1'b0;
            dout_n = 1'b0;
            ld     = 1'b1;
            ldv    = slot_is_tx(op_q, IDX_W'(idx + 1'b1)) ? CW'(C_TXREL - 1)
                                                            : CW'(C_C2D - 1);
          end
        end
      end

      default: begin
        st_n = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_START;
      last_q    <= 1'b0;
      idx       <= '0;
      sh        <= '0;
      ack_q     <= 1'b0;
      scl_o     <= 1'b1;
      sda_oe    <= 1'b0;
      sda_o     <= 1'b0;
      cmd_ready <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      rsp_nack  <= 1'b0;
    end else begin
      st        <= st_n;
      op_q      <= op_n;
      last_q    <= last_n;
      idx       <= idx_n;
      sh        <= sh_n;
      ack_q     <= ack_n;
      scl_o     <= scl_n;
      sda_oe    <= oe_n;
      sda_o     <= dout_n;
      cmd_ready <= (st_n == S_IDLE);
      rsp_done  <= fin;
      if (fin && (op_q == OP_READ)) begin
        rsp_rdata <= sh;
      end
      if (fin && (op_q == OP_WRITE)) begin
        rsp_nack <= ack_q;
      end
    end
  end

endmodule

// File: rtl/i2c_bit_seq_chk.sv
module i2c_bit_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       rsp_done,
  input logic [7:0] rsp_rdata,
  input logic       rsp_nack,
  input logic       scl_o,
  input logic       sda_oe,
  input logic       sda_o
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (scl_o && !sda_oe && cmd_ready && !rsp_done));

  // R7
  scl_fall_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_o) |-> !(sda_oe && sda_o));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> cmd_ready);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> rsp_done);

  // R9
  nack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_nack) |-> rsp_done);

endmodule

bind i2c_bit_seq i2c_bit_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rsp_done  (rsp_done),
  .rsp_rdata (rsp_rdata),
  .rsp_nack  (rsp_nack),
  .scl_o     (scl_o),
  .sda_oe    (sda_oe),
  .sda_o     (sda_o)
);

// File: tb/test_i2c_bit_seq.sv
module test_i2c_bit_seq;
  import i2cseq_pkg::*;

  // expected phase lengths, from fast-mode ns at 125 cycles per 10 us
  localparam int CL  = 1300 * 125 / 10000;
  localparam int CH  = 600 * 125 / 10000;
  localparam int CSU = 100 * 125 / 10000;
  localparam int CHD = 600 * 125 / 10000;
  localparam int CSS = 600 * 125 / 10000;
  localparam int CSP = 600 * 125 / 10000;
  localparam int CBF = 1300 * 125 / 10000;
  localparam int CCD = 900 * 125 / 10000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [1:0] cmd_op;
  logic [7:0] cmd_wdata;
  logic       cmd_last;
  logic       rsp_done;
  logic [7:0] rsp_rdata;
  logic       rsp_nack;
  logic       scl_o;
  logic       sda_oe;
  logic       sda_o;
  logic       sda_in;
  logic       tgt = 1'b1;

  int   n_chk = 0;
  int   n_bad = 0;
  int   poke_left = 0;
  logic cur_scl = 1'b1;
  logic [7:0] exp_rdata = 8'h00;
  logic       exp_nack = 1'b0;

  always #5 clk = ~clk;

  // open-drain bus: low if anyone pulls low
  assign sda_in = (sda_oe && !sda_o) ? 1'b0 : tgt;

  i2c_bit_seq i_i2c_bit_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .cmd_last  (cmd_last),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .rsp_nack  (rsp_nack),
    .scl_o     (scl_o),
    .sda_oe    (sda_oe),
    .sda_o     (sda_o),
    .sda_in    (sda_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // n cycles of expected pins while busy
  task automatic cyc(input int n, input logic s, input logic oe, input logic o,
                     input string req, input bit glitch);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (poke_left > 0) begin
        cmd_op = OP_STOP;
        poke_left--;
        if (poke_left == 0) cmd_valid = 1'b0;
      end
      if (glitch && i == n - 2) tgt = ~tgt;
      chk({scl_o, sda_oe, sda_o, cmd_ready, rsp_done} === {s, oe, o, 2'b00}, req,
          int'({scl_o, sda_oe, sda_o, cmd_ready, rsp_done}), int'({s, oe, o, 2'b00}));
    end
    cur_scl = s;
  endtask

  task automatic issue(input i2cseq_op_e op, input logic [7:0] wd, input logic last,
                       input int poke);
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R8 ready while idle", cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_wdata = wd;
    cmd_last  = last;
    poke_left = (poke > 0) ? poke : 1;
    @(posedge clk);
  endtask

  task automatic finish_cmd();
    @(negedge clk);
    chk(rsp_done === 1'b1 && cmd_ready === 1'b1, "R8 done with ready",
        int'({rsp_done, cmd_ready}), 3);
    chk(rsp_rdata === exp_rdata, "R9 R6 read data", rsp_rdata, exp_rdata);
    chk(rsp_nack === exp_nack, "R9 R5 ack status", rsp_nack, exp_nack);
    @(negedge clk);
    chk(rsp_done === 1'b0, "R8 single-cycle done", rsp_done, 0);
  endtask

  task automatic tx_bit(input logic b);
    tgt = 1'b1;
    cyc(CCD - CSU, 1'b0, 1'b0, 1'b0, "R4 released before data", 1'b0);
    cyc(CSU, 1'b0, 1'b1, b, "R4 data setup", 1'b0);
    cyc(CH, 1'b1, 1'b1, b, "R4 data high", 1'b0);
    cyc(CL - CCD, 1'b0, 1'b0, 1'b0, "R7 release on SCL low", 1'b0);
  endtask

  task automatic rx_bit(input logic lvl, input bit glitch, input string req);
    tgt = lvl;
    cyc(CCD, 1'b0, 1'b0, 1'b0, req, 1'b0);
    cyc(CH, 1'b1, 1'b0, 1'b0, req, glitch);
    cyc(CL - CCD, 1'b0, 1'b0, 1'b0, "R7 receive tail released", 1'b0);
  endtask

  task automatic do_start();
    issue(OP_START, 8'h00, 1'b0, 0);
    tgt = 1'b1;
    cyc(CSS, 1'b1, 1'b1, 1'b1, "R2 start setup", 1'b0);
    cyc(CHD, 1'b1, 1'b1, 1'b0, "R2 start hold", 1'b0);
    cyc(CL, 1'b0, 1'b1, 1'b0, "R2 start clock low", 1'b0);
    finish_cmd();
  endtask

  task automatic do_stop();
    logic s0;
    s0 = cur_scl;
    issue(OP_STOP, 8'h00, 1'b0, 0);
    tgt = 1'b1;
    cyc(CCD, s0, 1'b1, 1'b0, "R3 stop data low", 1'b0);
    cyc(CSP, 1'b1, 1'b1, 1'b0, "R3 stop setup", 1'b0);
    cyc(CBF, 1'b1, 1'b0, 1'b0, "R3 bus free", 1'b0);
    finish_cmd();
  endtask

  task automatic do_write(input logic [7:0] wd, input logic ack_lvl, input int poke);
    issue(OP_WRITE, wd, 1'b0, poke);
    for (int i = 0; i < 8; i++) tx_bit(wd[7-i]);
    rx_bit(ack_lvl, 1'b0, "R5 ack slot");
    exp_nack = ack_lvl;
    finish_cmd();
  endtask

  task automatic do_read(input logic [7:0] byt, input logic last, input bit glitch);
    issue(OP_READ, 8'h00, last, 0);
    for (int i = 0; i < 8; i++) rx_bit(byt[7-i], glitch, glitch ? "R10 late SDA change" : "R6 read slot");
    tx_bit(last);
    exp_rdata = byt;
    finish_cmd();
  endtask

  initial begin
    cmd_valid = 1'b0;
    cmd_op    = OP_START;
    cmd_wdata = 8'h00;
    cmd_last  = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({scl_o, sda_oe, sda_o, cmd_ready, rsp_done} === 5'b10010, "R1 reset idle",
        int'({scl_o, sda_oe, sda_o, cmd_ready, rsp_done}), 5'b10010);

    do_start();
    do_write(8'hA5, 1'b0, 0);
    do_write(8'h3C, 1'b1, 6);   // R8 request while busy ignored
    do_read(8'h96, 1'b0, 1'b0);
    do_read(8'h5A, 1'b1, 1'b1); // R6 NACK on last, R10 glitch
    do_stop();
    repeat (10) begin
      @(negedge clk);
      chk(scl_o === 1'b1 && sda_oe === 1'b0, "R3 bus idle after stop",
          int'({scl_o, sda_oe}), 2);
    end
    do_start();                 // R9 holds across START
    do_write(8'hFF, 1'b0, 0);
    do_write(8'h01, 1'b0, 0);
    do_stop();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule